// File: doc/BRIEF.md
# CAN Receive Bit Sampler

This block converts an oversampled CAN receive line into a stream of sampled bits. The fabric clock runs freely. Two configuration inputs set the nominal bit length in clocks and the sample position as a percentage of that length. While idle, the sampler watches the synchronized line. Once the line reads dominant (logic 0), it starts acquiring bits and produces one sample per bit at the configured point.

Bit sample times are not produced by a counter that restarts every bit. Each one is worked out from a timing reference: the clock count and bit index captured at the most recent recessive-to-dominant transition. The sample for bit n falls at reference count + width × (n − reference index) + offset. Each falling edge captures a new reference, so a transmitter that runs slightly fast or slow is followed. The sampler does not know about stuffing. Stuff bits advance the index like any other bit, and the downstream frame decoder drops them. A frame-done / abort pulse from that decoder sends the sampler back to idle.

Top module: `can_bit_sampler`

## Requirements
- R1: After synchronous reset, `bit_valid`, `bit_value` and `bit_index` are 0 and the block is idle.
- R2: While idle and the synchronized line is recessive, no strobe is produced. The receive input passes through a two-stage synchronizer. The clock edge at which the synchronized line first reads dominant starts acquisition with bit index 0, and that edge's clock count becomes the reference.
- R3: The sample offset is floor(width × pct / 100) clocks, with pct above 100 treated as 100. It is recomputed one clock after the configuration changes. When the line falls at the input and acquisition is idle, the first strobe is seen offset + 3 clocks later.
- R4: In acquisition, the sample for bit n is taken at the clock whose count equals ref_count + width × (n − ref_index) + offset.
- R5: Every recessive-to-dominant transition of the synchronized line during acquisition moves the reference to the current clock count and the current (not yet sampled) bit index.
- R6: `bit_index` rises by exactly one per strobe, modulo 2^IDX_W. Long runs without edges keep producing strobes at one bit width apart.
- R7: `bit_value` is the synchronized line level at the sample clock. `bit_value` and `bit_index` hold their last values between strobes.
- R8: A `frame_done` pulse returns the block to idle with its timing state cleared. It overrides a sample due in the same clock, and no strobe follows until the line reads dominant again.
- R9: When a falling edge and a sample fall in the same clock, the sample is taken on the old timing, and the next sample is due one width plus offset later.
- R10: `bit_valid` is a single-clock pulse, provided width ≥ 2 and offset ≥ 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous CAN receive line, 0 = dominant |
| cfg_bit_width | input | WIDTH_W | Nominal bit length in clocks (clock rate / bit rate) |
| cfg_sample_pct | input | PCT_W | Sample point in percent of the bit (typically 70) |
| frame_done | input | 1 | One-clock pulse: frame finished or aborted, return to idle |
| bit_valid | output | 1 | One-clock strobe: a bit was sampled |
| bit_value | output | 1 | Sampled line level |
| bit_index | output | IDX_W | Index of the sampled bit since start of frame |

## Verification
The bench aims at the clocks where re-referencing decides the result. Bits longer or shorter than nominal check that each falling edge moves the reference. A sampler that kept a fixed bit counter would drift and sample the wrong bit. Random short run lengths push edges onto the exact sample clock, where a design that re-references before sampling would skip or double a sample. Explicit latency checks with a non-integer offset (25 clocks at 62%) catch rounding instead of truncation. Aborts issued mid-frame, and also during quiet recessive stretches, expose a sampler that keeps strobing or keeps its old index after `frame_done`.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACQ  = 1'b1
  } cbs_state_e;

  localparam int PCT_FULL = 100;
endpackage

// File: rtl/cbs_rx_sync.sv
module cbs_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_async,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b1;
    else     chain_q[0] <= rx_async;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b1;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign line = chain_q[STAGES-1];
  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/cbs_offset.sv
module cbs_offset
  import cbs_pkg::*;
#(
  parameter int WIDTH_W = 16,
  parameter int PCT_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH_W-1:0] cfg_width,
  input  logic [PCT_W-1:0]   cfg_pct,
  output logic [WIDTH_W-1:0] width_q,
  output logic [WIDTH_W-1:0] off_q
);
  localparam int PROD_W = WIDTH_W + PCT_W;

  logic [PCT_W-1:0]   pct_eff;
  logic [PROD_W-1:0]  prod;
  logic [WIDTH_W-1:0] off_d;

  always_comb begin
    pct_eff = (int'(cfg_pct) > PCT_FULL) ? PCT_W'(PCT_FULL) : cfg_pct;
    prod    = PROD_W'(cfg_width) * PROD_W'(pct_eff);
    off_d   = WIDTH_W'(prod / PROD_W'(PCT_FULL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= '0;
      off_q   <= '0;
    end else begin
      width_q <= cfg_width;
      off_q   <= off_d;
    end
  end

  // R3: truncated offset never exceeds one bit
  a_r3_offset_in_bit: assert property (@(posedge clk) disable iff (rst)
    off_q <= width_q);
endmodule

// File: rtl/cbs_timing.sv
module cbs_timing #(
  parameter int CNT_W   = 24,
  parameter int WIDTH_W = 16,
  parameter int IDX_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               start,
  input  logic               run,
  input  logic               fall,
  input  logic [WIDTH_W-1:0] width,
  input  logic [WIDTH_W-1:0] off,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  localparam int PAD = CNT_W - WIDTH_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] w_ext;
  logic [CNT_W-1:0] o_ext;

  assign w_ext = {{PAD{1'b0}}, width};
  assign o_ext = {{PAD{1'b0}}, off};
  assign hit   = run && (cnt_q == tgt_q);
  assign idx   = idx_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      tgt_q <= '0;
      idx_q <= '0;
    end else if (start) begin
      tgt_q <= cnt_q + o_ext;
      idx_q <= '0;
    end else if (run) begin
      if (hit) idx_q <= idx_q + IDX_W'(1);
      if (fall)     tgt_q <= cnt_q + o_ext + (hit ? w_ext : '0);
      else if (hit) tgt_q <= tgt_q + w_ext;
    end
  end

  // R4: the pending sample is never further away than one offset plus one bit
  a_r4_target_window: assert property (@(posedge clk) disable iff (rst)
    (run && !hit) |-> ((tgt_q - cnt_q) <= (o_ext + w_ext)));
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
  import cbs_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int WIDTH_W     = 16,
  parameter int PCT_W       = 7,
  parameter int IDX_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_in,
  input  logic [WIDTH_W-1:0] cfg_bit_width,
  input  logic [PCT_W-1:0]   cfg_sample_pct,
  input  logic               frame_done,
  output logic               bit_valid,
  output logic               bit_value,
  output logic [IDX_W-1:0]   bit_index
);
  cbs_state_e         st_q;
  logic               s_line, s_fall;
  logic [WIDTH_W-1:0] width_q, off_q;
  logic               start, run, hit;
  logic [IDX_W-1:0]   idx;

  cbs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rx_async(rx_in), .line(s_line), .fall(s_fall)
  );

  cbs_offset #(.WIDTH_W(WIDTH_W), .PCT_W(PCT_W)) u_off (
    .clk(clk), .rst(rst), .cfg_width(cfg_bit_width), .cfg_pct(cfg_sample_pct),
    .width_q(width_q), .off_q(off_q)
  );

  assign start = (st_q == ST_IDLE) && !s_line && !frame_done;
  assign run   = (st_q == ST_ACQ) && !frame_done;

  cbs_timing #(.CNT_W(CNT_W), .WIDTH_W(WIDTH_W), .IDX_W(IDX_W)) u_tim (
    .clk(clk), .rst(rst), .clear(frame_done), .start(start), .run(run),
    .fall(s_fall), .width(width_q), .off(off_q), .hit(hit), .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (rst || frame_done) st_q <= ST_IDLE;
    else if (start)        st_q <= ST_ACQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_valid <= 1'b0;
      bit_value <= 1'b0;
      bit_index <= '0;
    end else begin
      bit_valid <= hit;
      if (hit) begin
        bit_value <= s_line;
        bit_index <= idx;
      end
    end
  end

  // R2: no strobe follows an idle clock
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |=> !bit_valid);
  // R8: abort wins and parks the block
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (!bit_valid && st_q == ST_IDLE));
  // R6: the running index is one ahead of the bit just reported
  a_r6_index_step: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (idx == bit_index + IDX_W'(1)));
  // R10: strobes are isolated pulses under legal configuration
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && width_q >= WIDTH_W'(2) && off_q >= WIDTH_W'(1)) |=> !bit_valid);
endmodule

// File: tb/can_bit_sampler_tb.sv
`timescale 1ns/1ps
module can_bit_sampler_tb;
  localparam int IDX_W = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_in = 1'b1;
  logic [15:0] cfg_bit_width = 16'd20;
  logic [6:0]  cfg_sample_pct = 7'd70;
  logic        frame_done = 1'b0;
  logic        bit_valid, bit_value;
  logic [IDX_W-1:0] bit_index;

  always #2.5 clk = ~clk;

  can_bit_sampler u_dut (
    .clk(clk), .rst(rst), .rx_in(rx_in), .cfg_bit_width(cfg_bit_width),
    .cfg_sample_pct(cfg_sample_pct), .frame_done(frame_done),
    .bit_valid(bit_valid), .bit_value(bit_value), .bit_index(bit_index)
  );

  int vectors = 0;
  int fails   = 0;
  string tag  = "R1";
  bit finished = 0;

  // ---------------- behavioural reference ----------------
  int  mc, rc, ri, mi, eidx, off;
  bit  m1, m2, m3, acq, ev, evl, hitm, fl;

  always @(posedge clk) begin
    if (rst) begin
      mc = 0; m1 = 1; m2 = 1; m3 = 1; acq = 0; rc = 0; ri = 0; mi = 0;
      ev = 0; evl = 0; eidx = 0;
    end else begin
      fl  = m3 && !m2;
      ev  = 0;
      off = (int'(cfg_bit_width) * ((cfg_sample_pct > 100) ? 100 : int'(cfg_sample_pct))) / 100;
      if (frame_done) begin
        acq = 0; rc = 0; ri = 0; mi = 0;
      end else if (!acq) begin
        if (!m2) begin acq = 1; rc = mc; ri = 0; mi = 0; end
      end else begin
        hitm = ((mc - rc) == int'(cfg_bit_width) * (mi - ri) + off);
        if (hitm) begin ev = 1; evl = m2; eidx = mi % (1 << IDX_W); end
        if (fl) begin rc = mc; ri = mi; end
        if (hitm) mi = mi + 1;
      end
      mc = mc + 1; m3 = m2; m2 = m1; m1 = rx_in;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  int  strb = 0;
  bit  arm = 0;
  time t_first;
  always @(negedge clk) begin
    if (!rst) begin
      check(bit_valid == ev, {tag, " R10 strobe"}, bit_valid, ev);
      check(bit_value == evl, {tag, " R7 value"}, bit_value, evl);
      check(int'(bit_index) == eidx, {tag, " R6 index"}, bit_index, eidx);
      if (bit_valid) strb++;
      if (arm && bit_valid) begin t_first = $time; arm = 0; end
    end
  end

  // ---------------- stimulus helpers ----------------
  int unsigned lcg = 32'h1234_5678;
  function automatic int unsigned nxt();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg >> 16;
  endfunction

  task automatic hold(input logic v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  // jit = 0: every bit is exactly len clocks; else len-jit .. len+jit
  task automatic send_frame(input int nbits, input int len, input int jit);
    for (int i = 0; i < nbits; i++) begin
      int l;
      l = len;
      if (jit > 0) l = len - jit + int'(nxt() % (2 * jit + 1));
      hold((i == 0) ? 1'b0 : logic'(nxt() & 1), l);
    end
  endtask

  task automatic first_latency(input string req, input int exp_clk);
    time t0;
    arm = 1; t0 = $time;
    send_frame(12, int'(cfg_bit_width), 0);
    check(arm == 0 && (t_first - t0) == exp_clk * 5, req,
          int'((t_first - t0) / 5), exp_clk);
  endtask

  // ---------------- sequence ----------------
  initial begin
    int s0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(bit_valid == 0 && bit_value == 0 && bit_index == 0, "R1 reset", bit_valid, 0);

    tag = "R2";
    hold(1'b1, 60);
    check(strb == 0, "R2 idle quiet", strb, 0);

    tag = "R3 R4";
    first_latency("R3 first sample 20/70", 17);
    tag = "R4 R7";
    send_frame(40, 20, 0);
    tag = "R6";
    hold(1'b1, 100);
    tag = "R8";
    pulse_done();
    s0 = strb;
    hold(1'b1, 30);
    check(strb == s0, "R8 quiet after abort", strb - s0, 0);

    cfg_bit_width = 16'd25; cfg_sample_pct = 7'd62;
    hold(1'b1, 6);
    tag = "R3";
    first_latency("R3 truncated offset 25/62", 18);
    tag = "R5 slow";
    send_frame(30, 27, 0);
    tag = "R5 fast";
    send_frame(30, 23, 0);
    hold(1'b1, 40);
    pulse_done();
    hold(1'b1, 10);

    cfg_bit_width = 16'd20; cfg_sample_pct = 7'd70;
    hold(1'b1, 6);
    tag = "R9 R5 jitter";
    send_frame(60, 20, 5);
    hold(1'b1, 30);
    pulse_done();
    hold(1'b1, 10);

    cfg_bit_width = 16'd10; cfg_sample_pct = 7'd50;
    hold(1'b1, 6);
    tag = "R9 short runs";
    send_frame(120, 9, 6);
    tag = "R8 mid-frame";
    pulse_done();
    send_frame(40, 10, 3);
    hold(1'b1, 30);
    pulse_done();
    hold(1'b1, 20);

    cfg_sample_pct = 7'd120;
    hold(1'b1, 6);
    tag = "R3 pct clamp";
    send_frame(20, 10, 2);
    hold(1'b1, 20);
    pulse_done();
    hold(1'b1, 10);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule